// File: doc/BRIEF.md
# Flow-Through Synchronous Byte-Write RAM

This block is a small synchronous RAM, by default sixteen words of 32 bits split into four 8-bit byte lanes. Address, write data and control are sampled on the rising clock edge. A read returns the addressed word in the cycle that follows the sampling edge. No extra output register sits in that path, so the read is flow-through.

Writes finish at the edge that samples them. A global-write input overrides every byte control and stores the whole word. Otherwise a byte-write gate, together with one enable per lane, picks which lanes are stored. Lanes that are not written keep their old contents.

Two chip enables (one active low, one active high) must both select the block for an access to take place. An active-low output enable and a drive flag control when read data is presented. A sleep input stops all accesses while it is held, and the stored contents are kept. The address comes from an outside source such as a burst counter.

Top module: `fts_ram`

## Requirements
- R1: While reset is held and after it is released, until a selected read is sampled, `dq_oe` is 0 and `rdata` is all zeros.
- R2: When a selected read (not sleeping, no lane resolving to a write) is sampled at a rising edge and `oe_n` is low, `rdata` carries the word at the sampled address from that edge until the next edge, and `dq_oe` is 1.
- R3: When `gw_n` is 0 on a selected edge, all four lanes of the addressed word are stored from `wdata`, whatever the values of `bwe_n` and `bw_n`.
- R4: When `gw_n` is 1 and `bwe_n` is 0 on a selected edge, exactly those lanes whose `bw_n` bit is 0 are stored. The other lanes keep their contents, and a later read returns the merged word.
- R5: When `gw_n` and `bwe_n` are both 1, the values of `bw_n` have no effect. The cycle is a read, and no stored data changes.
- R6: The block is selected only when `ce_n` is 0 and `ce` is 1. On an edge where it is not selected, nothing is stored, and `dq_oe` is 0 and `rdata` is zero until the next edge.
- R7: While `oe_n` is 1, `dq_oe` is 0 and `rdata` is zero, and the stored data is unaffected.
- R8: On an edge where `sleep` is 1, no write and no read takes place. While `sleep` is 1 the output is not driven. Every stored word is unchanged after sleep ends.
- R9: In the cycle after an edge that performs a write, `dq_oe` is 0 and `rdata` is zero.
- R10: Lane i holds bits [8i+7:8i] of a word and is controlled by bit i of `bw_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data, four 8-bit lanes |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Low-power standby; contents are kept |
| rdata | output | 32 | Read data, zero when not driven |
| dq_oe | output | 1 | High while `rdata` is being driven |

## Verification
A write is committed at the edge that samples it. Its effect can first be seen through a read sampled at a later edge, and that read's data appears right after its own edge. The bench therefore drives each cycle's inputs at the falling edge and samples one time unit after the next rising edge. At that point it compares `rdata` and `dq_oe` with a behavioural model that was updated at the same edge. Output gating by `oe_n` and `sleep` takes effect within the cycle, so those inputs are held steady across each sampling point.

// File: rtl/fts_ram.sv
module fts_ram #(
  parameter int WORDS  = 16,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW = LANES * LANE_W,
  localparam int AW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             ce_n,
  input  logic             ce,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    rdata,
  output logic             dq_oe
);

  logic [DW-1:0]    mem [WORDS];
  logic [AW-1:0]    addr_q;
  logic             rd_q;
  logic             sel;
  logic [LANES-1:0] lane_we;

  assign sel = !ce_n && ce && !sleep;

  always_comb begin
    lane_we = '0;
    if (sel) begin
      if (!gw_n)       lane_we = {LANES{1'b1}};
      else if (!bwe_n) lane_we = ~bw_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= addr;
      rd_q   <= sel && (lane_we == '0);
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++)
      if (lane_we[l])
        mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  assign dq_oe = rd_q && !oe_n && !sleep;
  assign rdata = dq_oe ? mem[addr_q] : '0;

endmodule

module fts_ram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          ce,
  input logic          gw_n,
  input logic          bwe_n,
  input logic          oe_n,
  input logic          sleep,
  input logic [DW-1:0] rdata,
  input logic          dq_oe
);

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !dq_oe) |-> (rdata == '0));

  assert_sleep_blocks_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !dq_oe);

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !ce) |=> !dq_oe);

  assert_global_write_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && ce && !sleep && !gw_n) |=> !dq_oe);

  assert_flow_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!ce_n && ce && !sleep && gw_n && bwe_n) && !oe_n && !sleep)
      |-> dq_oe);

endmodule

bind fts_ram fts_ram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .gw_n(gw_n),
  .bwe_n(bwe_n), .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .dq_oe(dq_oe)
);

// File: tb/tb_fts_ram.sv
module tb_fts_ram;
  localparam time PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        ce_n = 1'b1, ce = 1'b0, gw_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]  bw_n = 4'hF;
  logic        oe_n = 1'b1, sleep = 1'b0;
  logic [31:0] rdata;
  logic        dq_oe;

  int checks = 0, errors = 0;
  logic [31:0] ref_mem [16];
  logic        ref_rd = 1'b0;
  logic [3:0]  ref_addr = '0;

  always #(PER/2) clk = ~clk;

  fts_ram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n), .ce(ce),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep),
    .rdata(rdata), .dq_oe(dq_oe)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input string tag, input logic [31:0] exp_d, input logic exp_oe);
    checks++;
    if (rdata !== exp_d || dq_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s: rdata=%h dq_oe=%b expected rdata=%h dq_oe=%b", tag, rdata, dq_oe, exp_d, exp_oe);
    end
  endtask

  task automatic step(input logic [3:0] a, input logic [31:0] d, input logic cen, input logic ceh,
                      input logic gwn, input logic bwen, input logic [3:0] bwn, input logic oen,
                      input logic slp, input string tag);
    logic s, any;
    logic exp_oe;
    addr = a; wdata = d; ce_n = cen; ce = ceh; gw_n = gwn; bwe_n = bwen;
    bw_n = bwn; oe_n = oen; sleep = slp;
    @(posedge clk);
    s = !cen && ceh && !slp;
    any = 1'b0;
    if (s) begin
      for (int l = 0; l < 4; l++) begin
        if (!gwn || (!bwen && !bwn[l])) begin
          ref_mem[a][8*l +: 8] = d[8*l +: 8];
          any = 1'b1;
        end
      end
    end
    ref_rd = s && !any;
    ref_addr = a;
    #1;
    exp_oe = ref_rd && !oen && !slp;
    check(tag, exp_oe ? ref_mem[ref_addr] : 32'h0, exp_oe);
    @(negedge clk);
  endtask

  task automatic gwrite(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(a, d, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, tag);
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d, input logic [3:0] bwn, input string tag);
    step(a, d, 1'b0, 1'b1, 1'b1, 1'b0, bwn, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(a, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(PER * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(4'd0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, "R1 after reset");

    for (int i = 0; i < 16; i++) gwrite(i[3:0], 32'hA500_0000 + 32'(i) * 32'h0101_0203, "R3 R9 fill");
    for (int i = 0; i < 16; i++) rd(i[3:0], "R2 readback");

    step(4'd3, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 1'b0, 4'b1010, 1'b0, 1'b0, "R3 override bytes");
    rd(4'd3, "R3 whole word");

    bwrite(4'd5, 32'h1111_11C3, 4'b1110, "R4 R10 lane0");
    rd(4'd5, "R4 R10 lane0 merged");
    bwrite(4'd5, 32'h77EE_66DD, 4'b0101, "R4 R10 lanes1,3");
    rd(4'd5, "R4 R10 lanes1,3 merged");
    bwrite(4'd6, 32'hFFFF_FFFF, 4'b1111, "R4 no lane");
    rd(4'd6, "R4 no lane unchanged");

    step(4'd7, 32'h0BAD_0BAD, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, "R5 bw without gate");
    rd(4'd7, "R5 unchanged");

    step(4'd8, 32'hCAFE_0001, 1'b1, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R6 ce_n high");
    step(4'd8, 32'hCAFE_0002, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 1'b0, 1'b0, "R6 ce low");
    step(4'd8, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b0, "R6 deselect read");
    rd(4'd8, "R6 unchanged");

    step(4'd9, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b1, 1'b0, "R7 oe off");
    rd(4'd9, "R7 oe on");

    step(4'd10, 32'h5EE9_5EE9, 1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 1'b0, 1'b1, "R8 sleep write");
    step(4'd11, 32'h5EE9_0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, "R8 sleep bytes");
    step(4'd10, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, "R8 sleep read");
    for (int i = 0; i < 16; i++) rd(i[3:0], "R8 retained");

    gwrite(4'd12, 32'h0F0F_F0F0, "R9 write");
    rd(4'd12, "R2 read after write");
    bwrite(4'd12, 32'h00AB_0000, 4'b1011, "R9 byte write");
    rd(4'd12, "R2 R10 lane2 merged");

    summary();
    $finish;
  end
endmodule